// File: doc/BRIEF.md
# Variable-Latency Carry-Completion Adder

This block adds two n-bit operands and a carry input. Its latency depends on the data. The operand word is split into m = ceil(n/k) groups of k bits. Each cycle, the carry information may travel at most k bit positions, which stands for the delay budget of one group.

A completion tracker runs beside the sum. Each bit has two rails: carry known to be one, and carry known to be zero. The tracker raises `done` in the first cycle in which every bit has a resolved carry. A surrounding pipeline uses `done` as its capture enable and stall release. When several such adders share one pipeline, their `done` flags are combined with an AND outside this block.

Most additions finish in one cycle. Operands with a long run of propagate bits take two cycles, or up to m cycles. A start strobe loads the operands. While an addition is in flight the block is busy, the operands are held, and further strobes are ignored. An approximate mode can be selected with each start. In that mode the one-cycle result is accepted whether or not it is complete, which suits error-tolerant uses.

Top module: `vla_adder`

## Requirements
- R1: In exact mode, when `done` is high, `{carry_out, sum}` equals `op_a + op_b + carry_in` of the accepted start.
- R2: Let L be the longest run of consecutive bit positions where a XOR b is 1. In exact mode, `done` first rises in cycle N = max(1, ceil(L/k)). Cycle 1 is the cycle right after the clock edge that accepted the start.
- R3: While `done` is high, `mode` is 2'b00 when the addition took 1 cycle, 2'b01 when it took 2 cycles, and 2'b10 when it took 3 or more cycles.
- R4: While `done` is high, `cycles` equals the number of the current cycle after the start (1 for a one-cycle addition).
- R5: No addition takes more than m = ceil(n/k) cycles.
- R6: `busy` is high from cycle 1 through the cycle in which `done` is high, and low in the cycle after that.
- R7: A start strobe while `busy` is high is ignored. The operands in flight are held, and the result belongs to the first start.
- R8: With `approx` high at start, `done` is high in cycle 1 with mode 2'b00. Any carry not resolved within k positions of its source is taken as 0 in `sum` and `carry_out`.
- R9: After reset, `busy` and `done` are low.
- R10: `done` is high only while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Load operands and begin an addition (ignored while busy) |
| approx | input | 1 | Accept the first-cycle result, captured with start |
| op_a | input | WIDTH | First operand |
| op_b | input | WIDTH | Second operand |
| carry_in | input | 1 | Carry into bit 0 |
| busy | output | 1 | Addition in flight |
| done | output | 1 | Result valid this cycle; stall release |
| sum | output | WIDTH | Sum bits |
| carry_out | output | 1 | Carry out of the top bit |
| mode | output | 2 | Latency class: 00 one cycle, 01 two, 10 more |
| cycles | output | $clog2(m+1) | Cycle number of the current addition |

## Verification
On every cycle, the assertions check several invariants:
- No bit has both of its carry rails set.
- A resolved bit stays resolved until the next start.
- `done` never appears without `busy`, and `busy` drops right after it.
- The cycle count stays within m.
- The operands hold steady while the addition is in flight.
- Approximate additions finish in their first cycle.

The bench scenarios cover what the assertions cannot. They show the exact sum and the cycle in which `done` rises against the longest-propagate-run metric. They also show the mode and count values, that a start strobe issued mid-addition is ignored, and the approximate sum with its dropped carries. These are checked over directed run lengths and random operands.

// File: rtl/vla_pkg.sv
package vla_pkg;

    typedef enum logic [1:0] {
        LAT_ONE  = 2'b00,
        LAT_TWO  = 2'b01,
        LAT_MANY = 2'b10
    } lat_class_e;

    function automatic int unsigned groups_of(input int unsigned n, input int unsigned k);
        return (n + k - 1) / k;
    endfunction

    function automatic lat_class_e class_of(input int unsigned cyc);
        if (cyc <= 1)
            return LAT_ONE;
        else if (cyc == 2)
            return LAT_TWO;
        else
            return LAT_MANY;
    endfunction

endpackage

// File: rtl/vla_carry_front.sv
module vla_carry_front #(
    parameter int WIDTH = 32,
    parameter int GRP   = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             busy,
    input  logic [WIDTH-1:0] prop,
    input  logic [WIDTH-1:0] gen,
    input  logic [WIDTH-1:0] kill,
    input  logic             cin,
    output logic [WIDTH-1:0] one_rail,
    output logic             all_known
);

    logic [WIDTH-1:0] one_q, zero_q;
    logic [WIDTH-1:0] zero_rail;

    // Stage 0: locally decided carries, plus the state kept from earlier cycles.
    // Each later stage lets the known front step one bit higher.
    for (genvar s = 0; s <= GRP; s++) begin : g_stage
        logic [WIDTH-1:0] r1, r0;
        if (s == 0) begin : g_base
            assign r1 = one_q | gen;
            assign r0 = zero_q | kill;
        end else begin : g_step
            assign r1 = g_stage[s-1].r1 | (prop & {g_stage[s-1].r1[WIDTH-2:0], cin});
            assign r0 = g_stage[s-1].r0 | (prop & {g_stage[s-1].r0[WIDTH-2:0], ~cin});
        end
    end

    assign one_rail  = g_stage[GRP].r1;
    assign zero_rail = g_stage[GRP].r0;
    assign all_known = &(one_rail | zero_rail);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            one_q  <= '0;
            zero_q <= '0;
        end else if (busy) begin
            one_q  <= one_rail;
            zero_q <= zero_rail;
        end
    end

    p_rails_disjoint_r1: assert property (@(posedge clk) disable iff (rst)
        (one_q & zero_q) == '0);

    p_known_monotone_r2: assert property (@(posedge clk) disable iff (rst)
        (busy && !clear) |=> (((one_q | zero_q) & $past(one_q | zero_q)) == $past(one_q | zero_q)));

endmodule

// File: rtl/vla_ctrl.sv
module vla_ctrl #(
    parameter int MAXC = 4,
    parameter int CW   = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          all_known,
    input  logic          apx,
    output logic          busy,
    output logic          accept,
    output logic          done,
    output logic [CW-1:0] cyc
);

    assign accept = start && !busy;
    assign done   = busy && (all_known || apx);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            cyc  <= '0;
        end else if (accept) begin
            busy <= 1'b1;
            cyc  <= CW'(1);
        end else if (busy) begin
            if (done)
                busy <= 1'b0;
            else
                cyc <= cyc + CW'(1);
        end
    end

    p_done_in_busy_r10: assert property (@(posedge clk) disable iff (rst)
        done |-> busy);

    p_cycle_limit_r5: assert property (@(posedge clk) disable iff (rst)
        busy |-> (int'(cyc) >= 1 && int'(cyc) <= MAXC));

    p_busy_drops_r6: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy);

endmodule

// File: rtl/vla_adder.sv
module vla_adder
    import vla_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int GRP   = 8,
    localparam int NGRP = groups_of(WIDTH, GRP),
    localparam int CW   = $clog2(NGRP + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             approx,
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic             carry_in,
    output logic             busy,
    output logic             done,
    output logic [WIDTH-1:0] sum,
    output logic             carry_out,
    output logic [1:0]       mode,
    output logic [CW-1:0]    cycles
);

    logic [WIDTH-1:0] a_q, b_q;
    logic             cin_q, apx_q;
    logic             accept, all_known;
    logic [WIDTH-1:0] prop, gen, kill, one_rail;

    always_ff @(posedge clk) begin
        if (rst) begin
            a_q   <= '0;
            b_q   <= '0;
            cin_q <= 1'b0;
            apx_q <= 1'b0;
        end else if (accept) begin
            a_q   <= op_a;
            b_q   <= op_b;
            cin_q <= carry_in;
            apx_q <= approx;
        end
    end

    assign prop = a_q ^ b_q;
    assign gen  = a_q & b_q;
    assign kill = ~(a_q | b_q);

    vla_carry_front #(.WIDTH(WIDTH), .GRP(GRP)) u_front (
        .clk       (clk),
        .rst       (rst),
        .clear     (accept),
        .busy      (busy),
        .prop      (prop),
        .gen       (gen),
        .kill      (kill),
        .cin       (cin_q),
        .one_rail  (one_rail),
        .all_known (all_known)
    );

    vla_ctrl #(.MAXC(NGRP), .CW(CW)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .all_known (all_known),
        .apx       (apx_q),
        .busy      (busy),
        .accept    (accept),
        .done      (done),
        .cyc       (cycles)
    );

    // Unresolved carries read as zero on the one-rail.
    assign sum       = prop ^ {one_rail[WIDTH-2:0], cin_q};
    assign carry_out = one_rail[WIDTH-1];
    assign mode      = class_of(int'(cycles));

    p_hold_operands_r7: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> ($stable(a_q) && $stable(b_q) && $stable(cin_q)));

    p_approx_first_r8: assert property (@(posedge clk) disable iff (rst)
        (busy && apx_q) |-> done);

endmodule

// File: tb/vla_adder_tb.sv
module vla_adder_tb;

    localparam int W  = 16;
    localparam int K  = 6;
    localparam int M  = (W + K - 1) / K;
    localparam int CW = $clog2(M + 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic          approx = 1'b0;
    logic [W-1:0]  op_a = '0;
    logic [W-1:0]  op_b = '0;
    logic          carry_in = 1'b0;
    logic          busy, done, carry_out;
    logic [W-1:0]  sum;
    logic [1:0]    mode;
    logic [CW-1:0] cycles;

    int total = 0;
    int bad = 0;
    int mode_cnt [0:2];

    always #4 clk = ~clk;

    vla_adder #(.WIDTH(W), .GRP(K)) u_dut (
        .clk(clk), .rst(rst), .start(start), .approx(approx),
        .op_a(op_a), .op_b(op_b), .carry_in(carry_in),
        .busy(busy), .done(done), .sum(sum), .carry_out(carry_out),
        .mode(mode), .cycles(cycles)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int exp_cycles(input logic [W-1:0] a, input logic [W-1:0] b);
        int run = 0;
        int best = 0;
        for (int i = 0; i < W; i++) begin
            if (a[i] ^ b[i]) run++; else run = 0;
            if (run > best) best = run;
        end
        return (best == 0) ? 1 : (best + K - 1) / K;
    endfunction

    function automatic logic [W:0] approx_result(input logic [W-1:0] a, input logic [W-1:0] b,
                                                 input logic ci);
        logic [W:0] res;
        logic cval;
        int depth;
        logic cin_bit;
        cval = ci;
        depth = 0;
        cin_bit = ci;
        for (int i = 0; i < W; i++) begin
            res[i] = (a[i] ^ b[i]) ^ cin_bit;
            if (a[i] & b[i]) begin cval = 1'b1; depth = 0; end
            else if (!(a[i] | b[i])) begin cval = 1'b0; depth = 0; end
            else depth = depth + 1;
            cin_bit = (depth <= K) ? cval : 1'b0;
        end
        res[W] = cin_bit;
        return res;
    endfunction

    task automatic run_add(input logic [W-1:0] a, input logic [W-1:0] b, input logic ci,
                           input logic apx, input bit inject);
        int n = 1;
        int ec;
        logic [W:0] er;
        @(negedge clk);
        op_a = a; op_b = b; carry_in = ci; approx = apx; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (inject) begin
            op_a = ~a; op_b = b ^ 16'h00ff; carry_in = ~ci; start = 1'b1;
        end
        while (!done && n < 12) begin
            chk("R6 busy while pending", busy, 1);
            @(negedge clk);
            start = 1'b0;
            n++;
        end
        start = 1'b0;
        ec = apx ? 1 : exp_cycles(a, b);
        er = apx ? approx_result(a, b, ci) : ({1'b0, a} + {1'b0, b} + ci);
        chk(apx ? "R8 latency" : "R2 latency", n, ec);
        chk("R5 bound", (n <= M), 1);
        chk(apx ? "R8 result" : (inject ? "R7 result" : "R1 result"), {carry_out, sum}, er);
        chk("R4 cycles", cycles, ec);
        chk("R3 mode", mode, (ec == 1) ? 2'b00 : (ec == 2) ? 2'b01 : 2'b10);
        chk("R10 busy with done", busy, 1);
        if (ec <= 3) mode_cnt[ec-1]++;
        @(negedge clk);
        chk("R6 idle after", busy, 0);
        chk("R10 done low", done, 0);
    endtask

    initial begin
        #(8 * 190000);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 3; i++) mode_cnt[i] = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R9 busy reset", busy, 0);
        chk("R9 done reset", done, 0);
        // Directed propagate runs of every length, sourced from carry_in.
        for (int l = 0; l <= W; l++) begin
            run_add(W'((32'h1 << l) - 1), '0, 1'b1, 1'b0, 1'b0);
            run_add(W'((32'h1 << l) - 1), '0, 1'b0, 1'b0, 1'b0);
        end
        // Runs sourced from a generate bit at every position.
        for (int p = 0; p < W; p++)
            run_add(W'(32'hffff << p), W'(32'h1 << p), 1'b0, 1'b0, 1'b0);
        // R7: mid-flight start strobe must be ignored.
        run_add(16'hffff, 16'h0000, 1'b1, 1'b0, 1'b1);
        run_add(16'h0fff, 16'h0000, 1'b1, 1'b0, 1'b1);
        // R8: approximate mode on long and short runs.
        for (int l = 0; l <= W; l++)
            run_add(W'((32'h1 << l) - 1), '0, 1'b1, 1'b1, 1'b0);
        run_add(16'hfff1, 16'h0001, 1'b0, 1'b1, 1'b0);
        // Random operands, plain and biased toward long runs.
        for (int i = 0; i < 2000; i++) begin
            logic [W-1:0] a, b;
            a = W'($urandom);
            b = (i % 2 == 0) ? W'($urandom) : (~a ^ W'($urandom & $urandom & $urandom));
            run_add(a, b, 1'($urandom), 1'b0, 1'b0);
        end
        for (int i = 0; i < 300; i++) begin
            logic [W-1:0] a;
            a = W'($urandom);
            run_add(a, ~a ^ W'($urandom & $urandom), 1'($urandom), 1'b1, 1'b0);
        end
        $display("latency classes: one=%0d two=%0d more=%0d", mode_cnt[0], mode_cnt[1], mode_cnt[2]);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule